// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the pending-event flags and the per-source enable bits of a 16-bit free-running timer and merges them into a single interrupt request. The timer has three event sources. A rising edge on the capture pin copies the counter into a capture latch. A match between the counter and a programmable compare value is the second source. The counter wrapping from all ones to zero is the third. A small built-in event generator provides these three sources. Software reaches the block over a byte-wide register bus with separate read and write strobes. Read data is combinational and valid in the same cycle as the read strobe.

A flag never clears on a single bus access. Software first reads the status register while the flag is set, which arms that flag. A later access to the low byte of the register that belongs to that source then clears it. A flag that becomes set in the same cycle as its clearing access stays set. A global mask input blocks the request without touching any flag. Reset clears the flags and the timer state. The enable bits keep the value they had before reset.

Top module: `tmr_irq_ctl`

## Requirements
- R1: Each of the three events sets only its own flag. The status register is at address 0x13, with the capture flag at bit 7, the compare flag at bit 6 and the overflow flag at bit 5. Bits 4..0 read as zero.
- R2: The enable register is at address 0x12, with the capture, compare and overflow enables at bits 7, 6 and 5. A write stores only those three bits, and bits 4..0 read as zero. `irq_o` is high when at least one source has both its flag and its enable set, and the mask is low.
- R3: While `irq_mask_i` is high, `irq_o` is low, whatever the flags and enables are.
- R4: A rising edge of `cap_pin_i` latches the counter value into the capture register (high byte 0x14, low byte 0x15) and sets the capture flag. The capture flag clears on a read of 0x15 that follows a status read taken while the flag was set.
- R5: The compare register (high byte 0x16, low byte 0x17) is writable and resets to 0xFFFF. The compare flag sets in the cycle the counter equals the compare value. It clears on a read or a write of 0x17 that follows a status read taken while the flag was set.
- R6: The counter starts at 0 after reset and counts up by one every clock. It reads at 0x18 (high byte) and 0x19 (low byte). The overflow flag sets when the counter wraps from 0xFFFF to 0x0000. It clears on a read of 0x19 that follows a status read taken while the flag was set.
- R7: A clearing access has no effect on a flag that was not armed. A status read arms only the flags that are set at the moment of that read. A flag that becomes set after the read survives the next clearing access.
- R8: When an event sets a flag in the same cycle as an armed clearing access for that flag, the flag stays set.
- R9: Reset clears all flags, the counter and the capture latch. It leaves all three enable bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while `bus_rd_i` is high, zero otherwise |
| cap_pin_i | input | 1 | Capture pin, synchronous to `clk_i` |
| irq_mask_i | input | 1 | Global interrupt mask, blocks `irq_o` while high |
| irq_o | output | 1 | Combined timer interrupt request |

## Verification
Directed sequences show the difference between an armed clear and an unarmed one. They do this by issuing the low-byte access with no status read in front of it, and by issuing it after a status read that came before the flag was set. A capture edge placed in the same cycle as an armed capture-low read separates set-wins from clear-wins. A reset taken after programming the enables shows that those bits are kept. A long constrained-random phase then mixes reads, writes, compare reprogramming, capture edges and mask changes. Running a reference model alongside it exposes any mismatch in flag order, arming state or request gating. A final run across the counter wrap isolates the overflow source and its counter-low clear.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned CNT_W  = 2 * DATA_W;
    localparam int unsigned NSRC   = 3;

    // source indices: 0 capture, 1 compare, 2 overflow
    localparam int unsigned SRC_CAP = 0;
    localparam int unsigned SRC_CMP = 1;
    localparam int unsigned SRC_OVF = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h12;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h13;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 8'h14;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 8'h15;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 8'h16;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 8'h17;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h18;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h19;

    // register bit used by source i in both control and status
    function automatic int unsigned src_bit(input int unsigned idx);
        return DATA_W - 1 - idx;
    endfunction

endpackage

// File: rtl/tmr_evt_core.sv
module tmr_evt_core
    import tmr_irq_pkg::*;
#(
    parameter logic [CNT_W-1:0] CMP_RST = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_pin_i,
    input  logic              cmp_hi_wr_i,
    input  logic              cmp_lo_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [NSRC-1:0]   evt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] cmp;
        logic             pin_prev;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        evt_o[SRC_CAP] = cap_pin_i & ~core_q.pin_prev;
        evt_o[SRC_CMP] = (core_q.cnt == core_q.cmp);
        evt_o[SRC_OVF] = (core_q.cnt == '1);

        core_d.cnt      = core_q.cnt + 1'b1;
        core_d.pin_prev = cap_pin_i;
        if (evt_o[SRC_CAP]) begin
            core_d.cap = core_q.cnt;
        end
        if (cmp_hi_wr_i) begin
            core_d.cmp[CNT_W-1:DATA_W] = wdata_i;
        end
        if (cmp_lo_wr_i) begin
            core_d.cmp[DATA_W-1:0] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            core_q.cnt      <= '0;
            core_q.cap      <= '0;
            core_q.cmp      <= CMP_RST;
            core_q.pin_prev <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_o = core_q.cnt;
    assign cap_o = core_q.cap;
    assign cmp_o = core_q.cmp;

    // R4: a capture edge stores the counter value seen in that cycle
    a_r4_cap_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o[SRC_CAP] |=> (cap_o == $past(cnt_o)));

    // R6: the overflow event is followed by a zero count
    a_r6_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o[SRC_OVF] |=> (cnt_o == '0));

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (arm_i && cell_q.flag) begin
            cell_d.armed = 1'b1;
        end
        if (clr_i && cell_q.armed) begin
            cell_d.flag  = 1'b0;
            cell_d.armed = 1'b0;
        end
        if (set_i) begin
            cell_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign flag_o = cell_q.flag;

    // R1: an event always leaves the flag set
    a_r1_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_o);

    // R7: without a clearing access a set flag stays set
    a_r7_no_access_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_i) |=> flag_o);

    // R7: the arming state never outlives its flag
    a_r7_arm_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cell_q.armed |-> cell_q.flag);

    // R8: set and armed clear in one cycle leave the flag set
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && clr_i && cell_q.armed) |=> flag_o);

endmodule

// File: rtl/tmr_reg_if.sv
module tmr_reg_if
    import tmr_irq_pkg::*;
(
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   flags_i,
    input  logic [NSRC-1:0]   en_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic [CNT_W-1:0]  cmp_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              stat_rd_o,
    output logic              ctrl_wr_o,
    output logic              cmp_hi_wr_o,
    output logic              cmp_lo_wr_o,
    output logic [NSRC-1:0]   clr_o
);

    always_comb begin
        stat_rd_o      = rd_i && (addr_i == A_STAT);
        ctrl_wr_o      = wr_i && (addr_i == A_CTRL);
        cmp_hi_wr_o    = wr_i && (addr_i == A_CMP_HI);
        cmp_lo_wr_o    = wr_i && (addr_i == A_CMP_LO);
        clr_o[SRC_CAP] = rd_i && (addr_i == A_CAP_LO);
        clr_o[SRC_CMP] = (rd_i || wr_i) && (addr_i == A_CMP_LO);
        clr_o[SRC_OVF] = rd_i && (addr_i == A_CNT_LO);
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (addr_i)
                A_CTRL: begin
                    for (int i = 0; i < NSRC; i++) begin
                        rdata_o[src_bit(i)] = en_i[i];
                    end
                end
                A_STAT: begin
                    for (int i = 0; i < NSRC; i++) begin
                        rdata_o[src_bit(i)] = flags_i[i];
                    end
                end
                A_CAP_HI: rdata_o = cap_i[CNT_W-1:DATA_W];
                A_CAP_LO: rdata_o = cap_i[DATA_W-1:0];
                A_CMP_HI: rdata_o = cmp_i[CNT_W-1:DATA_W];
                A_CMP_LO: rdata_o = cmp_i[DATA_W-1:0];
                A_CNT_HI: rdata_o = cnt_i[CNT_W-1:DATA_W];
                A_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
                default:  rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tmr_irq_pkg::*;
#(
    parameter logic [CNT_W-1:0] CMP_RST = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              cap_pin_i,
    input  logic              irq_mask_i,
    output logic              irq_o
);

    logic [NSRC-1:0]  evt, clr, flags;
    logic [NSRC-1:0]  en_d, en_q;
    logic [CNT_W-1:0] cnt, cap, cmp;
    logic             stat_rd, ctrl_wr, cmp_hi_wr, cmp_lo_wr;

    tmr_reg_if u_reg_if (
        .rd_i        (bus_rd_i),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .flags_i     (flags),
        .en_i        (en_q),
        .cnt_i       (cnt),
        .cap_i       (cap),
        .cmp_i       (cmp),
        .rdata_o     (bus_rdata_o),
        .stat_rd_o   (stat_rd),
        .ctrl_wr_o   (ctrl_wr),
        .cmp_hi_wr_o (cmp_hi_wr),
        .cmp_lo_wr_o (cmp_lo_wr),
        .clr_o       (clr)
    );

    tmr_evt_core #(.CMP_RST(CMP_RST)) u_evt_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cap_pin_i   (cap_pin_i),
        .cmp_hi_wr_i (cmp_hi_wr),
        .cmp_lo_wr_i (cmp_lo_wr),
        .wdata_i     (bus_wdata_i),
        .cnt_o       (cnt),
        .cap_o       (cap),
        .cmp_o       (cmp),
        .evt_o       (evt)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        tmr_flag_cell u_flag (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (evt[g]),
            .arm_i  (stat_rd),
            .clr_i  (clr[g]),
            .flag_o (flags[g])
        );
    end

    // enables are deliberately outside the reset domain
    always_comb begin
        en_d = en_q;
        if (ctrl_wr) begin
            for (int i = 0; i < NSRC; i++) begin
                en_d[i] = bus_wdata_i[src_bit(i)];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        en_q <= en_d;
    end

    assign irq_o = !irq_mask_i && |(flags & en_q);

    // R9: enables change only on a control write
    a_r9_en_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> $stable(en_q));

    // R3: a request never appears while the mask is high
    a_r3_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> !irq_mask_i);

endmodule

// File: tb/test_tmr_irq_ctl.sv
`timescale 1ns/1ps
module test_tmr_irq_ctl;

    localparam logic [7:0] A_CTRL = 8'h12, A_STAT = 8'h13, A_CAP_HI = 8'h14,
                           A_CAP_LO = 8'h15, A_CMP_HI = 8'h16, A_CMP_LO = 8'h17,
                           A_CNT_HI = 8'h18, A_CNT_LO = 8'h19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       cap_pin = 1'b0, mask = 1'b0;
    logic       irq;

    int unsigned n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_irq_ctl i_tmr_irq_ctl (
        .clk_i(clk), .rst_ni(rst_n), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cap_pin_i(cap_pin), .irq_mask_i(mask), .irq_o(irq)
    );

    // reference model; index 0 capture, 1 compare, 2 overflow
    logic [15:0] m_cnt, m_cap, m_cmp;
    logic        m_prev;
    logic [2:0]  m_flag, m_arm;
    logic [2:0]  m_en = '0;

    always @(posedge clk or negedge rst_n) begin : mdl
        logic [2:0] ev, clr, nf, na;
        if (!rst_n) begin
            m_cnt <= '0; m_cap <= '0; m_cmp <= 16'hFFFF; m_prev <= 1'b0;
            m_flag <= '0; m_arm <= '0;
        end else begin
            ev[0]  = cap_pin & ~m_prev;
            ev[1]  = (m_cnt == m_cmp);
            ev[2]  = (m_cnt == 16'hFFFF);
            clr[0] = rd && addr == A_CAP_LO;
            clr[1] = (rd || wr) && addr == A_CMP_LO;
            clr[2] = rd && addr == A_CNT_LO;
            for (int i = 0; i < 3; i++) begin
                nf[i] = m_flag[i];
                na[i] = m_arm[i];
                if (rd && addr == A_STAT && m_flag[i]) na[i] = 1'b1;
                if (clr[i] && m_arm[i]) begin nf[i] = 1'b0; na[i] = 1'b0; end
                if (ev[i]) nf[i] = 1'b1;
            end
            m_flag <= nf;
            m_arm  <= na;
            if (wr && addr == A_CTRL) m_en <= {wdata[5], wdata[6], wdata[7]};
            if (wr && addr == A_CMP_HI) m_cmp[15:8] <= wdata;
            if (wr && addr == A_CMP_LO) m_cmp[7:0] <= wdata;
            if (ev[0]) m_cap <= m_cnt;
            m_cnt  <= m_cnt + 16'd1;
            m_prev <= cap_pin;
        end
    end

    function automatic logic [7:0] exp_rdata(input logic [7:0] a);
        case (a)
            A_CTRL:   return {m_en[0], m_en[1], m_en[2], 5'b0};
            A_STAT:   return {m_flag[0], m_flag[1], m_flag[2], 5'b0};
            A_CAP_HI: return m_cap[15:8];
            A_CAP_LO: return m_cap[7:0];
            A_CMP_HI: return m_cmp[15:8];
            A_CMP_LO: return m_cmp[7:0];
            A_CNT_HI: return m_cnt[15:8];
            A_CNT_LO: return m_cnt[7:0];
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return !mask && |(m_flag & m_en);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle, driven after a falling edge, sampled before the rising edge
    task automatic op(input logic r, input logic w, input logic [7:0] a,
                      input logic [7:0] wd, output logic [7:0] rv);
        rd = r; wr = w; addr = a; wdata = wd;
        #1;
        rv = rdata;
        check("R2 R3 irq", {15'd0, irq}, {15'd0, exp_irq()});
        if (r) check("R1 R4 R5 R6 rdata", {8'd0, rdata}, {8'd0, exp_rdata(a)});
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic idle(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 8'h00, 8'h00, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  v;
        logic [15:0] t;
        int unsigned sel;
        v = $urandom(32'h1F2E3D4C);
        @(negedge clk);
        do_reset();

        // R9: reset state
        op(1, 0, A_STAT, 0, v);   check("R9 status after reset", {8'd0, v}, 16'h0000);
        op(1, 0, A_CNT_HI, 0, v); check("R6 counter high after reset", {8'd0, v}, 16'h0000);
        op(1, 0, A_CMP_LO, 0, v); check("R5 compare reset low", {8'd0, v}, 16'h00FF);

        // R2: enable layout, unused bits
        op(0, 1, A_CTRL, 8'hFF, v);
        op(1, 0, A_CTRL, 0, v);   check("R2 ctrl readback", {8'd0, v}, 16'h00E0);

        // R4 capture, R7 unarmed access
        cap_pin = 1; idle(1); cap_pin = 0;
        #1; check("R2 irq from capture", {15'd0, irq}, 16'd1); @(negedge clk);
        op(1, 0, A_CAP_LO, 0, v);
        op(1, 0, A_STAT, 0, v);   check("R7 unarmed read keeps capture flag", {8'd0, v & 8'h80}, 16'h0080);
        op(1, 0, A_CAP_LO, 0, v);
        op(1, 0, A_STAT, 0, v);   check("R4 capture flag cleared", {8'd0, v & 8'h80}, 16'h0000);

        // R3 mask
        cap_pin = 1; idle(1); cap_pin = 0;
        mask = 1; #1; check("R3 mask blocks irq", {15'd0, irq}, 16'd0); @(negedge clk);
        mask = 0;
        op(1, 0, A_STAT, 0, v); op(1, 0, A_CAP_LO, 0, v);

        // R5 compare set and clear by write
        t = m_cnt + 16'd40;
        op(0, 1, A_CMP_HI, t[15:8], v); op(0, 1, A_CMP_LO, t[7:0], v);
        idle(50);
        op(1, 0, A_STAT, 0, v);   check("R5 compare flag set", {8'd0, v & 8'h40}, 16'h0040);
        op(0, 1, A_CMP_LO, t[7:0], v);
        op(1, 0, A_STAT, 0, v);   check("R5 compare flag cleared by write", {8'd0, v & 8'h40}, 16'h0000);

        // R7 read before set does not arm
        t = m_cnt + 16'd12;
        op(0, 1, A_CMP_HI, t[15:8], v); op(0, 1, A_CMP_LO, t[7:0], v);
        op(1, 0, A_STAT, 0, v);   check("R7 compare flag clear at read", {8'd0, v & 8'h40}, 16'h0000);
        idle(20);
        op(1, 0, A_CMP_LO, 0, v);
        op(1, 0, A_STAT, 0, v);   check("R7 late flag survives access", {8'd0, v & 8'h40}, 16'h0040);
        op(1, 0, A_CMP_LO, 0, v);

        // R8 set wins
        cap_pin = 1; idle(1); cap_pin = 0; idle(1);
        op(1, 0, A_STAT, 0, v);
        cap_pin = 1; op(1, 0, A_CAP_LO, 0, v); cap_pin = 0;
        op(1, 0, A_STAT, 0, v);   check("R8 set wins over clear", {8'd0, v & 8'h80}, 16'h0080);

        // R9 enables survive reset
        op(0, 1, A_CTRL, 8'h60, v);
        do_reset();
        op(1, 0, A_CTRL, 0, v);   check("R9 enables kept", {8'd0, v}, 16'h0060);
        op(1, 0, A_STAT, 0, v);   check("R9 flags cleared", {8'd0, v}, 16'h0000);

        // random phase
        for (int n = 0; n < 60000; n++) begin
            logic [7:0] a;
            sel = $urandom % 10;
            case (sel)
                0: a = A_CTRL;   1: a = A_STAT;   2: a = A_CAP_HI; 3: a = A_CAP_LO;
                4: a = A_CMP_HI; 5: a = A_CMP_LO; 6: a = A_CNT_HI; 7: a = A_CNT_LO;
                8: a = A_STAT;   default: a = 8'($urandom);
            endcase
            if ($urandom % 8 == 0) cap_pin = ~cap_pin;
            if ($urandom % 32 == 0) mask = ~mask;
            sel = $urandom % 4;
            op(sel == 1, sel == 2, a, 8'($urandom), v);
        end

        // R6 overflow around the wrap
        mask = 0; cap_pin = 0;
        op(0, 1, A_CTRL, 8'h20, v);
        op(1, 0, A_STAT, 0, v);
        op(1, 0, A_CAP_LO, 0, v); op(1, 0, A_CMP_LO, 0, v); op(1, 0, A_CNT_LO, 0, v);
        op(1, 0, A_STAT, 0, v);   check("R6 no overflow before wrap", {8'd0, v & 8'h20}, 16'h0000);
        while (m_cnt != 16'hFFFF) idle(1);
        idle(1);
        op(1, 0, A_STAT, 0, v);   check("R6 overflow flag set", {8'd0, v & 8'h20}, 16'h0020);
        check("R6 irq from overflow", {15'd0, irq}, 16'd1);
        op(1, 0, A_CNT_HI, 0, v);
        op(1, 0, A_STAT, 0, v);   check("R7 high byte leaves overflow", {8'd0, v & 8'h20}, 16'h0020);
        op(1, 0, A_CNT_LO, 0, v);
        op(1, 0, A_STAT, 0, v);   check("R6 overflow cleared", {8'd0, v & 8'h20}, 16'h0000);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule